// File: doc/BRIEF.md
# Three-Channel Timer Host Register Decoder

This block is the host-side register front end of a three-channel interval timer. The host sees four byte-wide ports. Ports 0, 1 and 2 are the data ports of channels 0, 1 and 2, and port 3 takes command bytes. The block does no counting itself. Each channel's counter lives outside it and reports its running count on `count_i`. The counter receives a programmed counting mode, a configuration pulse and a load strobe with a 16-bit reload value.

A command byte either programs a channel or takes a snapshot. Programming sets the channel's byte-access mode, which is low byte only, high byte only, or low-then-high word, and also sets its 3-bit counting mode. A snapshot command captures one channel's count, all counts at once, or a packed status byte for every channel. Data-port reads and writes in word mode are sequenced by per-channel byte-order toggles. Any pending status or count snapshot is served before the live count.

Top module: `timer_host_decoder`

## Requirements
- R1: After reset, every channel is in word access mode (code 11) with counting mode 0, with no snapshot pending and both toggles at the low byte. `load_o`, `cfg_o` and `mode_o` are all zero.
- R2: In a command byte, bits 7-6 name a group and bits 5-4 an operation. Bits 3-1 carry the counting mode, and bit 0 is ignored. For group 0-2, operation codes 01 (low only), 10 (high only) and 11 (word) set that channel's access mode and counting mode. They also reset its read and write toggles to the low byte.
- R3: A data-port write loads the channel one cycle later through `load_o`/`load_val_o`. In low-only mode the load value is {00,b}, and in high-only mode it is {b,00}. In word mode the first write is held and the second loads {second,first}.
- R4: A read with nothing pending returns a byte of the live count. That is the low byte in low-only mode and the high byte in high-only mode. In word mode successive reads alternate low, high, low.
- R5: Operation 00 for group 0-2 snapshots that channel's count. Later reads return the snapshot with the same byte order as R4 until its last byte has been read. Reads then return the live count again.
- R6: While a count snapshot is pending, further count-latch commands for that channel leave the snapshot unchanged.
- R7: Command nibble 1101 snapshots the counts of all channels in the same cycle. A channel that already has a pending snapshot keeps it.
- R8: Command nibble 1110 latches a status byte for every channel. In that byte bits 5-4 hold the access-mode code, bits 3-1 the counting mode, and bits 7, 6 and 0 are zero. The next read of a channel returns its status, which is then cleared. This takes priority over a pending count snapshot and does not move the read toggle.
- R9: Command nibbles 1100 and 1111 change no state. A read of port 3 returns 00.
- R10: `mode_o` gives each channel's programmed counting mode. `cfg_o` pulses for one cycle, one cycle after a programming command for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 2 | Port select: 0-2 channel data, 3 command |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; read side effects take place at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the port selected by `addr_i` (combinational) |
| count_i | input | 48 | Live 16-bit count of each channel, channel 0 in the low bits |
| load_o | output | 3 | One-cycle reload strobe per channel |
| load_val_o | output | 48 | Reload value per channel |
| mode_o | output | 9 | Counting mode per channel, 3 bits each |
| cfg_o | output | 3 | One-cycle configuration pulse per channel |

## Verification
The bench sweeps every access mode and every counting mode on every channel and reads back the packed status byte of all three channels after each step. A field packed into the wrong bits, or a status latch that is not set or cleared for every channel, shows up as a wrong byte. Snapshots are checked by changing the live count after the latch. A design that reads through to the live count, accepts a second latch, or clears the snapshot after the first byte of a word returns bytes of the wrong value. A status read in the middle of a word snapshot exposes a toggle that advances on status reads. A programming command given between the two bytes of a word write exposes a write toggle that is not reset. The two unused command nibbles are followed by status and live reads, which catch any state they disturb.

// File: rtl/timer_dec_pkg.sv
package timer_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_t;

  typedef struct packed {
    logic              latch;
    logic              setacc;
    logic              glatch;
    logic              slatch;
    logic [1:0]        grp;
    acc_t              acc;
    logic [MODE_W-1:0] mode;
  } cmd_t;

  // status byte: 0 0 | access | mode | 0
  function automatic logic [BYTE_W-1:0] status_byte(acc_t a, logic [MODE_W-1:0] m);
    return {2'b00, a, m, 1'b0};
  endfunction

  function automatic logic pick_high(acc_t a, logic tog);
    return (a == ACC_HI) || ((a == ACC_WORD) && tog);
  endfunction

  function automatic logic last_byte(acc_t a, logic tog);
    return (a != ACC_WORD) || tog;
  endfunction

  function automatic logic [BYTE_W-1:0] byte_of(logic [WORD_W-1:0] w, logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] single_load(acc_t a, logic [BYTE_W-1:0] b);
    return (a == ACC_HI) ? {b, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, b};
  endfunction
endpackage

// File: rtl/timer_cmd_decode.sv
module timer_cmd_decode
  import timer_dec_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic       valid_i,
  input  logic [6:0] cmd_byte_i,
  output cmd_t       cmd_o
);
  logic [1:0]        grp;
  logic [1:0]        op;
  logic [MODE_W-1:0] mode;
  logic              chan_grp;
  logic              special_grp;

  assign grp         = cmd_byte_i[6:5];
  assign op          = cmd_byte_i[4:3];
  assign mode        = cmd_byte_i[2:0];
  assign special_grp = (grp == 2'b11);
  assign chan_grp    = !special_grp && (int'(grp) < NUM_CH);

  always_comb begin
    cmd_o        = '0;
    cmd_o.grp    = grp;
    cmd_o.acc    = acc_t'(op);
    cmd_o.mode   = mode;
    if (valid_i) begin
      if (chan_grp) begin
        cmd_o.latch  = (op == 2'b00);
        cmd_o.setacc = (op != 2'b00);
      end else if (special_grp) begin
        cmd_o.glatch = (op == 2'b01);
        cmd_o.slatch = (op == 2'b10);
      end
    end
  end
endmodule

// File: rtl/timer_chan_port.sv
module timer_chan_port
  import timer_dec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic                latch_i,
  input  logic                setacc_i,
  input  logic                slatch_i,
  input  acc_t                acc_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [WORD_W-1:0]   count_i,
  output logic [BYTE_W-1:0]   rd_byte_o,
  output logic                load_o,
  output logic [WORD_W-1:0]   load_val_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic                cfg_o
);
  acc_t              acc_q;
  logic [MODE_W-1:0] mode_q;
  logic              rtog_q, wtog_q;
  logic              lat_pend_q, st_pend_q;
  logic [WORD_W-1:0] lat_val_q;
  logic [BYTE_W-1:0] st_val_q;
  logic [BYTE_W-1:0] wlo_q;

  // named internal events
  logic rd_status, rd_count, rd_hi_sel, rd_last;
  logic latch_take, status_take, word_first, word_done, single_wr;

  assign rd_status   = rd_i && st_pend_q;
  assign rd_count    = rd_i && !st_pend_q;
  assign rd_hi_sel   = pick_high(acc_q, rtog_q);
  assign rd_last     = last_byte(acc_q, rtog_q);
  assign latch_take  = latch_i && !lat_pend_q;
  assign status_take = slatch_i && !st_pend_q;
  assign single_wr   = wr_i && (acc_q != ACC_WORD);
  assign word_first  = wr_i && (acc_q == ACC_WORD) && !wtog_q;
  assign word_done   = wr_i && (acc_q == ACC_WORD) && wtog_q;

  always_comb begin
    if (st_pend_q) rd_byte_o = st_val_q;
    else           rd_byte_o = byte_of(lat_pend_q ? lat_val_q : count_i, rd_hi_sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= ACC_WORD;
      mode_q     <= '0;
      rtog_q     <= 1'b0;
      wtog_q     <= 1'b0;
      lat_pend_q <= 1'b0;
      st_pend_q  <= 1'b0;
      lat_val_q  <= '0;
      st_val_q   <= '0;
      wlo_q      <= '0;
      load_o     <= 1'b0;
      load_val_o <= '0;
      cfg_o      <= 1'b0;
    end else begin
      load_o <= 1'b0;
      cfg_o  <= 1'b0;
      // data-port read side effects
      if (rd_status) st_pend_q <= 1'b0;
      if (rd_count) begin
        if (acc_q == ACC_WORD) rtog_q <= !rtog_q;
        if (lat_pend_q && rd_last) lat_pend_q <= 1'b0;
      end
      // data-port writes
      if (single_wr) begin
        load_o     <= 1'b1;
        load_val_o <= single_load(acc_q, wdata_i);
      end
      if (word_first) begin
        wlo_q  <= wdata_i;
        wtog_q <= 1'b1;
      end
      if (word_done) begin
        load_o     <= 1'b1;
        load_val_o <= {wdata_i, wlo_q};
        wtog_q     <= 1'b0;
      end
      // command effects
      if (latch_take) begin
        lat_pend_q <= 1'b1;
        lat_val_q  <= count_i;
      end
      if (status_take) begin
        st_pend_q <= 1'b1;
        st_val_q  <= status_byte(acc_q, mode_q);
      end
      if (setacc_i) begin
        acc_q  <= acc_i;
        mode_q <= mode_i;
        rtog_q <= 1'b0;
        wtog_q <= 1'b0;
        cfg_o  <= 1'b1;
      end
    end
  end

  assign mode_o = mode_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_pend_q && !rd_count) |=> (lat_pend_q && $stable(lat_val_q))); // R6

  AST_LATCH_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_pend_q) |-> (lat_val_q == $past(count_i))); // R5

  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !latch_i && !setacc_i) |=> (!st_pend_q && $stable(lat_pend_q) && $stable(rtog_q))); // R8

  AST_TOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    setacc_i |=> (!rtog_q && !wtog_q && cfg_o)); // R2

  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> $past(wr_i)); // R3

  AST_ACC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q != ACC_LATCH); // R2
endmodule

// File: rtl/timer_read_mux.sv
module timer_read_mux
  import timer_dec_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [1:0]               addr_i,
  input  logic [NUM_CH*BYTE_W-1:0] bytes_i,
  output logic [BYTE_W-1:0]        rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == 2'(i)) rdata_o = bytes_i[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/timer_host_decoder.sv
module timer_host_decoder
  import timer_dec_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               addr_i,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [BYTE_W-1:0]        wdata_i,
  output logic [BYTE_W-1:0]        rdata_o,
  input  logic [NUM_CH*WORD_W-1:0] count_i,
  output logic [NUM_CH-1:0]        load_o,
  output logic [NUM_CH*WORD_W-1:0] load_val_o,
  output logic [NUM_CH*MODE_W-1:0] mode_o,
  output logic [NUM_CH-1:0]        cfg_o
);
  localparam logic [1:0] CMD_PORT = 2'b11;

  cmd_t                     cmd;
  logic                     cmd_wr;
  logic                     cmd_none;
  logic [NUM_CH*BYTE_W-1:0] rd_bytes;

  assign cmd_wr   = wr_en_i && (addr_i == CMD_PORT);
  assign cmd_none = !(cmd.latch || cmd.setacc || cmd.glatch || cmd.slatch);

  timer_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .valid_i    (cmd_wr),
    .cmd_byte_i (wdata_i[7:1]),
    .cmd_o      (cmd)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic is_me;
    assign is_me = (cmd.grp == 2'(g));
    timer_chan_port u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_en_i && (addr_i == 2'(g))),
      .rd_i       (rd_en_i && (addr_i == 2'(g))),
      .wdata_i    (wdata_i),
      .latch_i    ((cmd.latch && is_me) || cmd.glatch),
      .setacc_i   (cmd.setacc && is_me),
      .slatch_i   (cmd.slatch),
      .acc_i      (cmd.acc),
      .mode_i     (cmd.mode),
      .count_i    (count_i[g*WORD_W +: WORD_W]),
      .rd_byte_o  (rd_bytes[g*BYTE_W +: BYTE_W]),
      .load_o     (load_o[g]),
      .load_val_o (load_val_o[g*WORD_W +: WORD_W]),
      .mode_o     (mode_o[g*MODE_W +: MODE_W]),
      .cfg_o      (cfg_o[g])
    );
  end

  timer_read_mux #(.NUM_CH(NUM_CH)) u_mux (
    .addr_i  (addr_i),
    .bytes_i (rd_bytes),
    .rdata_o (rdata_o)
  );

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.latch, cmd.setacc, cmd.glatch, cmd.slatch})); // R2

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_o)); // R3

  AST_IGNORED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_none) |=> ($stable(mode_o) && (cfg_o == '0))); // R9

  AST_CMDPORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == CMD_PORT) |-> (rdata_o == '0)); // R9
endmodule

// File: tb/timer_host_decoder_bench.sv
module timer_host_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'b00;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [15:0] cnt [3];
  logic [47:0] count_w;
  logic [2:0]  load;
  logic [47:0] load_val;
  logic [8:0]  mode;
  logic [2:0]  cfg;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [2:0]  cap_load, cap_cfg;
  logic [47:0] cap_val;
  int exp_acc [3];
  int exp_mode [3];

  always #10 clk = !clk;
  assign count_w = {cnt[2], cnt[1], cnt[0]};

  timer_host_decoder u_timer_host_decoder (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .count_i(count_w), .load_o(load),
    .load_val_o(load_val), .mode_o(mode), .cfg_o(cfg)
  );

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); cap_load = load; cap_val = load_val; cap_cfg = cfg; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic logic [7:0] cmdb(int grp, int op, int md);
    return 8'(grp * 64 + op * 16 + md * 2);
  endfunction

  task automatic prog(int ch, int acc, int md);
    wr(2'd3, cmdb(ch, acc, md));
    exp_acc[ch] = acc; exp_mode[ch] = md;
  endtask

  task automatic status_all(string tag);
    logic [7:0] v;
    wr(2'd3, 8'hE0);
    for (int c = 0; c < 3; c++) begin
      rd(2'(c), v);
      chk(tag, v, exp_acc[c] * 16 + exp_mode[c] * 2);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    cnt[0] = 16'h1234; cnt[1] = 16'h5678; cnt[2] = 16'h9ABC;
    for (int c = 0; c < 3; c++) begin exp_acc[c] = 3; exp_mode[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 load", int'(load), 0);
    chk("R1 cfg", int'(cfg), 0);
    chk("R1 mode", int'(mode), 0);
    rd(2'd0, v); chk("R1 word low first", v, 8'h34);
    rd(2'd0, v); chk("R1 word high second", v, 8'h12);
    status_all("R1 status after reset");

    // R2 R8 R10 exhaustive sweep of access and counting modes
    for (int c = 0; c < 3; c++)
      for (int a = 1; a < 4; a++)
        for (int m = 0; m < 8; m++) begin
          prog(c, a, m);
          chk("R10 cfg pulse", int'(cap_cfg), 1 << c);
          chk("R10 mode out", int'(mode[c*3 +: 3]), m);
          status_all("R8 R2 status sweep");
        end

    // R4 live reads
    prog(1, 1, 0);
    rd(2'd1, v); chk("R4 low only", v, 8'h78);
    rd(2'd1, v); chk("R4 low only again", v, 8'h78);
    prog(1, 2, 0);
    rd(2'd1, v); chk("R4 high only", v, 8'h56);
    prog(1, 3, 0);
    rd(2'd1, v); chk("R4 word low", v, 8'h78);
    rd(2'd1, v); chk("R4 word high", v, 8'h56);
    rd(2'd1, v); chk("R4 word low wrap", v, 8'h78);

    // R3 writes
    prog(2, 1, 0);
    wr(2'd2, 8'hA5); chk("R3 lo load", int'(cap_load), 4); chk("R3 lo val", int'(cap_val[47:32]), 16'h00A5);
    prog(2, 2, 0);
    wr(2'd2, 8'hA5); chk("R3 hi load", int'(cap_load), 4); chk("R3 hi val", int'(cap_val[47:32]), 16'hA500);
    prog(2, 3, 0);
    wr(2'd2, 8'h11); chk("R3 word first no load", int'(cap_load), 0);
    wr(2'd2, 8'h22); chk("R3 word load", int'(cap_load), 4); chk("R3 word val", int'(cap_val[47:32]), 16'h2211);
    // R2 toggle reset between word bytes
    wr(2'd2, 8'h11);
    prog(2, 3, 0);
    wr(2'd2, 8'h33); chk("R2 toggle reset no load", int'(cap_load), 0);
    wr(2'd2, 8'h44); chk("R2 toggle reset val", int'(cap_val[47:32]), 16'h4433);

    // R5 count snapshot
    prog(0, 3, 0);
    cnt[0] = 16'hBEEF;
    wr(2'd3, cmdb(0, 0, 0));
    cnt[0] = 16'h1111;
    rd(2'd0, v); chk("R5 snap low", v, 8'hEF);
    rd(2'd0, v); chk("R5 snap high", v, 8'hBE);
    rd(2'd0, v); chk("R5 live after", v, 8'h11);
    rd(2'd0, v);
    // R5 snapshot in high-only mode done after one byte
    prog(1, 2, 0);
    wr(2'd3, cmdb(1, 0, 0));
    cnt[1] = 16'h0F0F;
    rd(2'd1, v); chk("R5 single byte snap", v, 8'h56);
    rd(2'd1, v); chk("R5 single byte live", v, 8'h0F);

    // R6 second latch ignored
    cnt[0] = 16'h0102;
    wr(2'd3, cmdb(0, 0, 0));
    cnt[0] = 16'h0304;
    wr(2'd3, cmdb(0, 0, 0));
    rd(2'd0, v); chk("R6 first snap low", v, 8'h02);
    rd(2'd0, v); chk("R6 first snap high", v, 8'h01);

    // R7 general latch
    prog(1, 3, 0);
    cnt[0] = 16'hA1B2; cnt[1] = 16'hC3D4; cnt[2] = 16'hE5F6;
    wr(2'd3, 8'hD0);
    cnt[0] = 16'h0; cnt[1] = 16'h0; cnt[2] = 16'h0;
    rd(2'd0, v); chk("R7 ch0 low", v, 8'hB2);
    rd(2'd0, v); chk("R7 ch0 high", v, 8'hA1);
    rd(2'd1, v); chk("R7 ch1 low", v, 8'hD4);
    rd(2'd1, v); chk("R7 ch1 high", v, 8'hC3);
    rd(2'd2, v); chk("R7 ch2 low", v, 8'hF6);
    rd(2'd2, v); chk("R7 ch2 high", v, 8'hE5);

    // R8 status priority over a pending snapshot, toggle not moved
    prog(0, 3, 5);
    cnt[0] = 16'h7788;
    wr(2'd3, cmdb(0, 0, 0));
    wr(2'd3, 8'hE0);
    rd(2'd0, v); chk("R8 status first", v, 8'h3A);
    rd(2'd0, v); chk("R8 snap low after status", v, 8'h88);
    rd(2'd0, v); chk("R8 snap high after status", v, 8'h77);
    rd(2'd1, v); rd(2'd2, v);

    // R9 unused commands
    cnt[0] = 16'h4455;
    wr(2'd3, 8'hC0); chk("R9 no cfg C", int'(cap_cfg), 0);
    wr(2'd3, 8'hFE); chk("R9 no cfg F", int'(cap_cfg), 0);
    wr(2'd3, 8'hCE);
    chk("R9 mode kept", int'(mode[2:0]), 5);
    rd(2'd0, v); chk("R9 no latch taken", v, 8'h55);
    rd(2'd0, v); chk("R9 no latch taken hi", v, 8'h44);
    status_all("R9 status unchanged");
    rd(2'd3, v); chk("R9 command port reads zero", v, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule